// File: doc/BRIEF.md
# Pulse-Cell Disk Read Stream Serializer

This block drives the read-data line of an emulated vintage floppy drive. Bytes that have already been encoded are sent one bit per fixed-length cell, with the most significant bit first. A one bit makes a short high pulse at the very start of its cell. A zero bit leaves the line low for the whole cell. There is no separate clock line, so the receiver recovers the bits from pulse position alone, and the cell length must not vary by even one clock cycle.

The high time and the cell length are counted in system clock cycles. Both are derived at elaboration from the clock frequency and the wanted durations (4 µs cells with a 1 µs pulse). At 72 MHz this gives 288 cycles per cell, of which 72 are high.

Bytes come from a buffer split into two halves. The host writes bytes into a half and then commits that half. The block reports when it has taken the last byte of each half, so the host can refill that half while the other one streams; a 402-byte sector therefore passes through the halves in turn with no gap. If the half that is needed next has not been committed, the block flags an underrun and sends zero cells until that half arrives. An enable input starts and stops the stream only at cell boundaries.

Top module: `pulse_cell_serializer`

## Requirements
- R1: With the line enabled, every cell lasts exactly CELL_CYC = (CLK_FREQ_HZ/1000)*CELL_NS/1e6 clock cycles, and cells follow one another with no idle cycle between them.
- R2: A one bit drives `readPulse` high for the first HIGH_CYC = (CLK_FREQ_HZ/1000)*PULSE_NS/1e6 cycles of its cell and low for the rest of that cell.
- R3: A zero bit keeps `readPulse` low for the whole of its cell.
- R4: Each byte is sent bit 7 first and bit 0 last. Bytes are taken in address order: half 0 holds addresses 0 to HALF_BYTES-1, half 1 holds HALF_BYTES to 2*HALF_BYTES-1, and after the last address the read pointer wraps back to 0.
- R5: While the line is idle, a clock edge that samples `enable` high starts a cell; the first cycle of that cell is the cycle after that edge.
- R6: When `enable` falls in the middle of a cell, that cell still completes, and `readPulse` then stays low. Bits not yet sent stay queued and are sent when the stream is enabled again.
- R7: `hostCommit` marks the half selected by `hostCommitHalf` as full. When the last byte of a half is loaded for sending, that half is marked empty. A one-cycle pulse then appears during the first cycle of the cell carrying that byte's bit 7: `halfDone` for half 0 and `fullDone` for half 1.
- R8: If a new byte is needed at a cell boundary and the half it comes from is empty, `underrun` goes high and zero cells are sent. Once that half is committed, the next cell boundary loads its first byte and `underrun` goes low.
- R9: After reset `readPulse`, `halfDone`, `fullDone` and `underrun` are low, both halves are empty and the read pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the stream; sampled at cell boundaries |
| hostWrEn | input | 1 | Write one byte into the buffer |
| hostAddr | input | ADDR_W | Buffer byte address of the write |
| hostData | input | 8 | Encoded byte to write |
| hostCommit | input | 1 | Mark one half as full |
| hostCommitHalf | input | 1 | Half marked by `hostCommit` (0 or 1) |
| readPulse | output | 1 | Serial pulse-cell read data |
| halfDone | output | 1 | One-cycle strobe: half 0 taken, may be refilled |
| fullDone | output | 1 | One-cycle strobe: half 1 taken, may be refilled |
| underrun | output | 1 | High while zero cells are sent for lack of data |

## Verification
The bench compares every cell against the queue of expected bits. An off-by-one in the cell counter shifts every later pulse and breaks the pattern check for the cells that follow. A pulse that is one cycle too long or too short fails the same check. The bench refills each half while the other half streams. A design that skips the wrap of the read pointer, or that clears the wrong half's full flag, then sends stale or zero bytes where fresh bytes are expected. The bench also lets the buffer run dry, commits a half in the middle of a filler cell, and stops the stream in the middle of a byte. These cases expose a resume that starts before the next boundary, a missing underrun flag, and a stop that cuts the current cell short or loses the bits still queued.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

  // Strobes from the control unit to the datapath, valid for one cycle.
  typedef struct packed {
    logic cellStart; // begin a new cell on the next cycle
    logic lineStop;  // return the line to idle
    logic loadByte;  // take the byte at the read address
    logic shiftBit;  // advance to the next bit of the held byte
    logic sendZero;  // filler cell, no data available
  } pcsStrobe_t;

endpackage

// File: rtl/pcs_datapath.sv
module pcs_datapath
  import pcs_pkg::*;
#(
  parameter int CELL_CYC   = 288,
  parameter int HIGH_CYC   = 72,
  parameter int HALF_BYTES = 16,
  parameter int ADDR_W     = $clog2(2 * HALF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  pcsStrobe_t        strobe,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostData,
  output logic              cellLast,
  output logic              lineActive,
  output logic              readPulse
);

  localparam int BUF_BYTES = 2 * HALF_BYTES;
  localparam int CNT_W     = $clog2(CELL_CYC);
  localparam logic [ADDR_W:0]  BUF_EXT  = (ADDR_W + 1)'(BUF_BYTES);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CELL_CYC - 1);
  localparam logic [CNT_W-1:0] CNT_HIGH = CNT_W'(HIGH_CYC);

  logic [7:0]       bufMem [BUF_BYTES];
  logic [7:0]       fetched;
  logic [6:0]       shReg;
  logic             curBit;
  logic [CNT_W-1:0] cellCnt;

  // Byte store for both halves, written by the host.
  always_ff @(posedge clk) begin
    if (hostWrEn && ({1'b0, hostAddr} < BUF_EXT)) begin
      bufMem[hostAddr] <= hostData;
    end
  end

  assign fetched = bufMem[rdAddr];

  // Cell timer: runs from 0 to CELL_CYC-1 while the line is active.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cellCnt    <= '0;
      lineActive <= 1'b0;
    end else if (strobe.cellStart) begin
      cellCnt    <= '0;
      lineActive <= 1'b1;
    end else if (strobe.lineStop) begin
      cellCnt    <= '0;
      lineActive <= 1'b0;
    end else if (lineActive && !cellLast) begin
      cellCnt <= cellCnt + 1'b1;
    end
  end

  // Bit shifter: curBit is the bit of the cell in flight, MSB first.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curBit <= 1'b0;
      shReg  <= '0;
    end else if (strobe.lineStop) begin
      curBit <= 1'b0;
    end else if (strobe.loadByte) begin
      {curBit, shReg} <= fetched;
    end else if (strobe.shiftBit) begin
      {curBit, shReg} <= {shReg, 1'b0};
    end else if (strobe.sendZero) begin
      curBit <= 1'b0;
    end
  end

  assign cellLast  = lineActive && (cellCnt == CNT_LAST);
  assign readPulse = lineActive && curBit && (cellCnt < CNT_HIGH);

  // R1: a new cell is only started from idle or at the last cycle of a cell
  a_r1_start_at_boundary: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cellStart |-> (!lineActive || cellLast));

  // R2: a pulse always ends exactly HIGH_CYC cycles into its cell
  a_r2_pulse_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readPulse) |-> (lineActive && cellCnt == CNT_HIGH));

endmodule

// File: rtl/pcs_control.sv
module pcs_control
  import pcs_pkg::*;
#(
  parameter int HALF_BYTES = 16,
  parameter int ADDR_W     = $clog2(2 * HALF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              hostCommit,
  input  logic              hostCommitHalf,
  input  logic              cellLast,
  input  logic              lineActive,
  output pcsStrobe_t        strobe,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              halfDone,
  output logic              fullDone,
  output logic              underrun
);

  localparam int NUM_HALVES = 2;
  localparam logic [ADDR_W:0] HALF_EXT  = (ADDR_W + 1)'(HALF_BYTES);
  localparam logic [ADDR_W:0] LAST0_EXT = (ADDR_W + 1)'(HALF_BYTES - 1);
  localparam logic [ADDR_W:0] LAST1_EXT = (ADDR_W + 1)'(2 * HALF_BYTES - 1);

  logic [2:0]            bitsLeft;
  logic [NUM_HALVES-1:0] halfValid;
  logic                  rdHalf;
  logic                  lastInHalf;
  logic                  boundary;
  logic                  consume;
  logic [ADDR_W-1:0]     nextAddr;

  assign boundary   = !lineActive || cellLast;
  assign rdHalf     = ({1'b0, rdAddr} >= HALF_EXT);
  assign lastInHalf = ({1'b0, rdAddr} == LAST0_EXT) || ({1'b0, rdAddr} == LAST1_EXT);
  assign nextAddr   = ({1'b0, rdAddr} == LAST1_EXT) ? '0 : rdAddr + 1'b1;
  assign consume    = strobe.loadByte && lastInHalf;

  // Decision taken at every cell boundary.
  always_comb begin
    strobe = '0;
    if (boundary) begin
      if (enable) begin
        strobe.cellStart = 1'b1;
        if (bitsLeft != 3'd0) begin
          strobe.shiftBit = 1'b1;
        end else if (halfValid[rdHalf]) begin
          strobe.loadByte = 1'b1;
        end else begin
          strobe.sendZero = 1'b1;
        end
      end else begin
        strobe.lineStop = 1'b1;
      end
    end
  end

  // Read pointer, bit count, underrun and release strobes.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitsLeft <= '0;
      rdAddr   <= '0;
      underrun <= 1'b0;
      halfDone <= 1'b0;
      fullDone <= 1'b0;
    end else begin
      halfDone <= consume && !rdHalf;
      fullDone <= consume && rdHalf;
      if (strobe.loadByte) begin
        bitsLeft <= 3'd7;
        rdAddr   <= nextAddr;
        underrun <= 1'b0;
      end else if (strobe.shiftBit) begin
        bitsLeft <= bitsLeft - 1'b1;
      end else if (strobe.sendZero) begin
        underrun <= 1'b1;
      end
    end
  end

  // One full flag per half: set by a host commit, cleared on release.
  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    logic validQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        validQ <= 1'b0;
      end else if (hostCommit && (hostCommitHalf == 1'(h))) begin
        validQ <= 1'b1;
      end else if (consume && (rdHalf == 1'(h))) begin
        validQ <= 1'b0;
      end
    end
    assign halfValid[h] = validQ;
  end

  // R7: the two release strobes never fire together
  a_r7_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({halfDone, fullDone}));

  // R7: half 0 is marked empty when its release strobe is seen
  a_r7_half_released: assert property (@(posedge clk) disable iff (!rstN)
    (halfDone && !$past(hostCommit && !hostCommitHalf)) |-> !halfValid[0]);

  // R4: after half 0 is released the pointer sits at the start of half 1
  a_r4_ptr_after_half: assert property (@(posedge clk) disable iff (!rstN)
    halfDone |-> ({1'b0, rdAddr} == HALF_EXT));

  // R4: after half 1 is released the pointer has wrapped to 0
  a_r4_ptr_wrap: assert property (@(posedge clk) disable iff (!rstN)
    fullDone |-> (rdAddr == '0));

  // R8: an underrun only begins with no bits left in the held byte
  a_r8_underrun_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(underrun) |-> (bitsLeft == 3'd0));

endmodule

// File: rtl/pulse_cell_serializer.sv
module pulse_cell_serializer
  import pcs_pkg::*;
#(
  parameter int CLK_FREQ_HZ = 72_000_000,
  parameter int CELL_NS     = 4000,
  parameter int PULSE_NS    = 1000,
  parameter int HALF_BYTES  = 16,
  parameter int ADDR_W      = $clog2(2 * HALF_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              hostWrEn,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [7:0]        hostData,
  input  logic              hostCommit,
  input  logic              hostCommitHalf,
  output logic              readPulse,
  output logic              halfDone,
  output logic              fullDone,
  output logic              underrun
);

  localparam int CLK_KHZ  = CLK_FREQ_HZ / 1000;
  localparam int CELL_CYC = CLK_KHZ * CELL_NS / 1_000_000;
  localparam int HIGH_CYC = CLK_KHZ * PULSE_NS / 1_000_000;

  pcsStrobe_t        strobe;
  logic [ADDR_W-1:0] rdAddr;
  logic              cellLast;
  logic              lineActive;

  pcs_control #(
    .HALF_BYTES(HALF_BYTES),
    .ADDR_W    (ADDR_W)
  ) u_ctl (
    .clk           (clk),
    .rstN          (rstN),
    .enable        (enable),
    .hostCommit    (hostCommit),
    .hostCommitHalf(hostCommitHalf),
    .cellLast      (cellLast),
    .lineActive    (lineActive),
    .strobe        (strobe),
    .rdAddr        (rdAddr),
    .halfDone      (halfDone),
    .fullDone      (fullDone),
    .underrun      (underrun)
  );

  pcs_datapath #(
    .CELL_CYC  (CELL_CYC),
    .HIGH_CYC  (HIGH_CYC),
    .HALF_BYTES(HALF_BYTES),
    .ADDR_W    (ADDR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdAddr    (rdAddr),
    .hostWrEn  (hostWrEn),
    .hostAddr  (hostAddr),
    .hostData  (hostData),
    .cellLast  (cellLast),
    .lineActive(lineActive),
    .readPulse (readPulse)
  );

endmodule

// File: tb/sim_pulse_cell_serializer.sv
module sim_pulse_cell_serializer;

  localparam int CLK_FREQ_HZ = 4_000_000;
  localparam int HALF_BYTES  = 2;
  localparam int ADDR_W      = 2;
  localparam int CELL_CYC    = 16;  // 4000 kHz * 4000 ns / 1e6
  localparam int HIGH_CYC    = 4;   // 4000 kHz * 1000 ns / 1e6

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              enable = 1'b0;
  logic              hostWrEn = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic [7:0]        hostData = '0;
  logic              hostCommit = 1'b0;
  logic              hostCommitHalf = 1'b0;
  logic              readPulse, halfDone, fullDone, underrun;

  int  checksRun = 0;
  int  checksFailed = 0;
  int  halfCnt = 0;
  int  fullCnt = 0;
  int  monCell = 0;
  bit  finished = 1'b0;
  bit  expQ[$];

  always #10 clk = ~clk;  // 50 MHz

  pulse_cell_serializer #(
    .CLK_FREQ_HZ(CLK_FREQ_HZ),
    .HALF_BYTES (HALF_BYTES),
    .ADDR_W     (ADDR_W)
  ) u0 (
    .clk(clk), .rstN(rstN), .enable(enable),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostData(hostData),
    .hostCommit(hostCommit), .hostCommitHalf(hostCommitHalf),
    .readPulse(readPulse), .halfDone(halfDone), .fullDone(fullDone),
    .underrun(underrun)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checksRun++;
    if (!ok) begin
      checksFailed++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checksRun - checksFailed, checksRun);
      $finish;
    end
  endtask

  // Driver: fill one half, commit it, queue its bits MSB first.
  task automatic writeHalf(input int h, input logic [7:0] b0, input logic [7:0] b1);
    logic [7:0] pair [2];
    pair[0] = b0;
    pair[1] = b1;
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      hostWrEn = 1'b1;
      hostAddr = ADDR_W'(h * HALF_BYTES + i);
      hostData = pair[i];
    end
    @(negedge clk);
    hostWrEn       = 1'b0;
    hostCommit     = 1'b1;
    hostCommitHalf = 1'(h);
    for (int i = 0; i < 2; i++)
      for (int b = 7; b >= 0; b--) expQ.push_back(pair[i][b]);
    @(negedge clk);
    hostCommit = 1'b0;
  endtask

  // Monitor: one check per cell; empty queue means a zero cell.
  task automatic monitorCells(input int n, input string tag);
    for (int c = 0; c < n; c++) begin
      bit expBit;
      bit good;
      int highs;
      expBit  = (expQ.size() > 0) ? expQ.pop_front() : 1'b0;
      monCell = c;
      good    = 1'b1;
      highs   = 0;
      for (int i = 0; i < CELL_CYC; i++) begin
        @(negedge clk);
        if (readPulse) highs++;
        if (readPulse !== (expBit && (i < HIGH_CYC))) good = 1'b0;
      end
      check(good, tag, highs, expBit ? HIGH_CYC : 0);
    end
  endtask

  always @(negedge clk) begin
    if (halfDone) halfCnt++;
    if (fullDone) fullCnt++;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checksRun++;
    checksFailed++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    finishRun();
  end

  initial begin
    int highs;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9: reset state
    check(readPulse === 1'b0, "R9 readPulse after reset", int'(readPulse), 0);
    check(underrun === 1'b0, "R9 underrun after reset", int'(underrun), 0);
    check({halfDone, fullDone} === 2'b00, "R9 release strobes after reset",
          int'({halfDone, fullDone}), 0);

    writeHalf(0, 8'hA5, 8'h3C);
    writeHalf(1, 8'h81, 8'h7E);
    highs = 0;
    repeat (CELL_CYC) begin @(negedge clk); if (readPulse) highs++; end
    check(highs == 0, "R5 line low before enable", highs, 0);

    // Streaming with refills while the other half is sent (R1 R2 R3 R4 R5 R7).
    @(negedge clk);
    enable = 1'b1;
    fork
      monitorCells(68, "R1/R2/R3/R4/R5/R7 stream cell");
      begin
        do @(negedge clk); while (!halfDone);
        writeHalf(0, 8'hF0, 8'h0F);
        do @(negedge clk); while (!fullDone);
        writeHalf(1, 8'h55, 8'hC3);
      end
    join
    // R8: buffer ran dry, filler zeros were sent above
    check(underrun === 1'b1, "R8 underrun while starved", int'(underrun), 1);
    check(halfCnt == 2, "R7 half-0 releases", halfCnt, 2);
    check(fullCnt == 2, "R7 half-1 releases", fullCnt, 2);

    // R8: commit in the middle of a filler cell, resume at next boundary from address 0.
    fork
      monitorCells(19, "R8/R4 resume cell");
      begin
        repeat (CELL_CYC / 2) @(negedge clk);
        writeHalf(0, 8'h96, 8'h69);
        repeat (2 * CELL_CYC) @(negedge clk);
        check(underrun === 1'b0, "R8 underrun cleared on resume", int'(underrun), 0);
      end
    join
    check(underrun === 1'b1, "R8 underrun after second drain", int'(underrun), 1);

    // R6: stop in the middle of a byte.
    fork
      monitorCells(6, "R6/R3 pre-stop cell");
      begin
        repeat (CELL_CYC / 2) @(negedge clk);
        writeHalf(1, 8'hB4, 8'h2D);
        wait (monCell == 5);
        repeat (4) @(negedge clk);
        enable = 1'b0;
      end
    join
    highs = 0;
    repeat (3 * CELL_CYC) begin @(negedge clk); if (readPulse) highs++; end
    check(highs == 0, "R6 line low after stop", highs, 0);

    // R5/R6: restart from idle, remaining bits follow.
    @(negedge clk);
    enable = 1'b1;
    monitorCells(13, "R5/R6 restart cell");
    check(halfCnt == 3, "R7 half-0 releases total", halfCnt, 3);
    check(fullCnt == 3, "R7 half-1 releases total", fullCnt, 3);
    check(expQ.size() == 0, "R4 all queued bits sent", expQ.size(), 0);
    finishRun();
  end

endmodule